// File: doc/BRIEF.md
# Self-clearing soft reset controller

This block lets a host start a software reset by writing a 1 to a self-clearing control bit. The sequence runs only when both PHY clocks, the receive clock and the transmit clock, are seen toggling. While it runs, the block drives a reset strobe for the MAC control registers for a fixed number of cycles. It also reloads the unprotected bits of a small system register and clears the latched transmit and receive error flags. If either PHY clock is absent, the reset gives up after a fixed number of system cycles. No strobe is issued in that case, and a read-only timeout flag is set instead.

The block also holds the host write gate. After a hardware reset, a completed soft reset or a wake event, every host write is dropped until the host has made at least one read. A read-only bit reports the bus width strap, which is sampled once after reset. Each PHY clock has its own activity monitor. A monitor reports its clock as running when the synchronised clock has shown an edge within a fixed window of system cycles.

Top module: `soft_reset_ctrl`

## Requirements
- R1: After a hardware reset, address 0 reads bit 0 (reset busy) = 0 and bit 1 (timeout) = 0, address 1 reads SYS_RST, and mac_rst_o, err_tx_o and err_rx_o are 0.
- R2: Host writes to either address have no effect until a host read (host_rd_i high for one cycle) has occurred.
- R3: With both PHY clocks running, a write of 1 to bit 0 at address 0 sets bit 0. mac_rst_o is then high for exactly RST_CYC cycles, after which bit 0 reads 0 and bit 1 stays 0.
- R4: If a PHY clock is not running, the request never raises mac_rst_o. About TIMEOUT_CYC cycles after the write, bit 0 clears and bit 1 reads 1.
- R5: A new reset request (write of 1 to bit 0) clears bit 1 in the cycle after the write.
- R6: A completed soft reset loads the bits of the system register (address 1) outside PROT_MASK with SYS_RST and keeps the bits inside PROT_MASK.
- R7: A completed soft reset clears err_tx_o and err_rx_o, which otherwise latch high after a pulse on err_tx_set_i or err_rx_set_i.
- R8: After a completed soft reset or a wake_i pulse, host writes are again ignored until the next host read.
- R9: Bit 2 of address 0 reports the value strap_bus32_i had in the first cycle after hardware reset and does not follow later changes.
- R10: A PHY clock counts as running only if its edge was seen within the last WINDOW system cycles. A stopped transmit clock alone makes a request time out.
- R11: Writing 0 to bit 0 at address 0 starts no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| phy_rx_clk_i | input | 1 | PHY receive clock, asynchronous |
| phy_tx_clk_i | input | 1 | PHY transmit clock, asynchronous |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | 0: control/status, 1: system register |
| host_wdata_i | input | SYS_W | Write data |
| host_rdata_o | output | SYS_W | Read data for host_addr_i |
| wake_i | input | 1 | Return from power-saving state |
| strap_bus32_i | input | 1 | Bus width strap |
| err_tx_set_i | input | 1 | Transmit error event |
| err_rx_set_i | input | 1 | Receive error event |
| err_tx_o | output | 1 | Latched transmit error |
| err_rx_o | output | 1 | Latched receive error |
| mac_rst_o | output | 1 | Reset strobe for MAC control registers |

## Verification
The bench builds the block with its default values: WINDOW of 16, TIMEOUT_CYC of 64, RST_CYC of 4, an 8-bit system register with PROT_MASK 8'hF0 and SYS_RST 8'h05. The short window and timeout let one run stop each PHY clock, wait for its monitor to drop, let a request time out, restart the clocks and run a reset to completion. The mixed mask and reset value let the six table vectors show kept and reloaded bits in the same register.

// File: rtl/sr_pkg.sv
package sr_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WAIT  = 2'd1,
        SQ_RESET = 2'd2
    } sq_state_e;

    localparam int CTL_BUSY_BIT  = 0;
    localparam int CTL_TMO_BIT   = 1;
    localparam int CTL_BUS32_BIT = 2;
endpackage

// File: rtl/sr_clk_mon.sv
module sr_clk_mon #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phy_clk_i,
    output logic running_o
);
    localparam int CW = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [2:0]    sync;
        logic [CW-1:0] cnt;
        logic          running;
    } mon_t;

    mon_t st_d, st_q;
    logic edge_seen;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], phy_clk_i};
        edge_seen = st_q.sync[1] ^ st_q.sync[2];
        if (edge_seen) begin
            st_d.cnt     = '0;
            st_d.running = 1'b1;
        end else if (st_q.cnt == CW'(WINDOW - 1)) begin
            st_d.running = 1'b0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign running_o = st_q.running;
endmodule

// File: rtl/sr_seq.sv
module sr_seq
    import sr_pkg::*;
#(
    parameter int TIMEOUT_CYC = 64,
    parameter int RST_CYC     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clk_ok_i,
    output logic busy_o,
    output logic rst_active_o,
    output logic timeout_o,
    output logic done_o
);
    localparam int MAXC = (TIMEOUT_CYC > RST_CYC) ? TIMEOUT_CYC : RST_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        sq_state_e     state;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        timeout_o = 1'b0;
        done_o    = 1'b0;
        unique case (st_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    st_d.state = SQ_WAIT;
                    st_d.cnt   = '0;
                end
            end
            SQ_WAIT: begin
                if (clk_ok_i) begin
                    st_d.state = SQ_RESET;
                    st_d.cnt   = '0;
                end else if (st_q.cnt == CW'(TIMEOUT_CYC - 1)) begin
                    st_d.state = SQ_IDLE;
                    timeout_o  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            SQ_RESET: begin
                if (st_q.cnt == CW'(RST_CYC - 1)) begin
                    st_d.state = SQ_IDLE;
                    done_o     = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{state: SQ_IDLE, cnt: '0};
        else        st_q <= st_d;
    end

    assign busy_o       = (st_q.state != SQ_IDLE);
    assign rst_active_o = (st_q.state == SQ_RESET);
endmodule

// File: rtl/soft_reset_ctrl.sv
module soft_reset_ctrl
    import sr_pkg::*;
#(
    parameter int               WINDOW      = 16,
    parameter int               TIMEOUT_CYC = 64,
    parameter int               RST_CYC     = 4,
    parameter int               SYS_W       = 8,
    parameter logic [SYS_W-1:0] PROT_MASK   = 8'hF0,
    parameter logic [SYS_W-1:0] SYS_RST     = 8'h05
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phy_rx_clk_i,
    input  logic             phy_tx_clk_i,
    input  logic             host_rd_i,
    input  logic             host_wr_i,
    input  logic             host_addr_i,
    input  logic [SYS_W-1:0] host_wdata_i,
    output logic [SYS_W-1:0] host_rdata_o,
    input  logic             wake_i,
    input  logic             strap_bus32_i,
    input  logic             err_tx_set_i,
    input  logic             err_rx_set_i,
    output logic             err_tx_o,
    output logic             err_rx_o,
    output logic             mac_rst_o
);
    localparam int NCLK = 2;

    typedef struct packed {
        logic             timeout;
        logic             unlocked;
        logic             err_tx;
        logic             err_rx;
        logic [SYS_W-1:0] sys;
        logic             bus32;
        logic             strap_taken;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NCLK-1:0] phy_clks;
    logic [NCLK-1:0] clk_run;
    logic clk_ok, busy, rst_active, tmo_evt, done_evt;
    logic wr_ok, start;

    assign phy_clks = {phy_tx_clk_i, phy_rx_clk_i};

    for (genvar g = 0; g < NCLK; g++) begin : g_mon
        sr_clk_mon #(.WINDOW(WINDOW)) u_mon (
            .clk       (clk),
            .rst_n     (rst_n),
            .phy_clk_i (phy_clks[g]),
            .running_o (clk_run[g])
        );
    end

    assign clk_ok = &clk_run;

    sr_seq #(.TIMEOUT_CYC(TIMEOUT_CYC), .RST_CYC(RST_CYC)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .clk_ok_i     (clk_ok),
        .busy_o       (busy),
        .rst_active_o (rst_active),
        .timeout_o    (tmo_evt),
        .done_o       (done_evt)
    );

    assign wr_ok = host_wr_i && regs_q.unlocked;
    assign start = wr_ok && !host_addr_i && host_wdata_i[CTL_BUSY_BIT] && !busy;

    always_comb begin
        regs_d = regs_q;
        // bus width strap is captured once
        if (!regs_q.strap_taken) begin
            regs_d.bus32       = strap_bus32_i;
            regs_d.strap_taken = 1'b1;
        end
        // write gate: a read arms it, wake or a finished reset disarms it
        if (host_rd_i)            regs_d.unlocked = 1'b1;
        if (wake_i || done_evt)   regs_d.unlocked = 1'b0;
        // timeout status
        if (start)   regs_d.timeout = 1'b0;
        if (tmo_evt) regs_d.timeout = 1'b1;
        // error latches, cleared by the active reset
        if (err_tx_set_i) regs_d.err_tx = 1'b1;
        if (err_rx_set_i) regs_d.err_rx = 1'b1;
        if (wr_ok && host_addr_i) regs_d.sys = host_wdata_i;
        if (rst_active) begin
            regs_d.err_tx = 1'b0;
            regs_d.err_rx = 1'b0;
            regs_d.sys    = (regs_q.sys & PROT_MASK) | (SYS_RST & ~PROT_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.sys      <= SYS_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        host_rdata_o = '0;
        if (host_addr_i) begin
            host_rdata_o = regs_q.sys;
        end else begin
            host_rdata_o[CTL_BUSY_BIT]  = busy;
            host_rdata_o[CTL_TMO_BIT]   = regs_q.timeout;
            host_rdata_o[CTL_BUS32_BIT] = regs_q.bus32;
        end
    end

    assign err_tx_o  = regs_q.err_tx;
    assign err_rx_o  = regs_q.err_rx;
    assign mac_rst_o = rst_active;
endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
    parameter int               SYS_W     = 8,
    parameter logic [SYS_W-1:0] PROT_MASK = 8'hF0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             mac_rst,
    input logic             done,
    input logic             timeout,
    input logic             unlocked,
    input logic             host_wr,
    input logic             host_addr,
    input logic [SYS_W-1:0] sys,
    input logic             err_tx,
    input logic             err_rx
);
    // R3: the MAC strobe is only seen while the reset bit reads busy
    a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rst |-> busy);

    // R4: a timeout flag appears only out of a request that never strobed
    a_r4_timeout_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> ($past(busy) && !$past(mac_rst)));

    // R6: protected system bits survive the strobe
    a_r6_protected_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rst |=> ((sys & PROT_MASK) == ($past(sys) & PROT_MASK)));

    // R7: error latches are clear after a strobe cycle
    a_r7_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rst |=> (!err_tx && !err_rx));

    // R8: a finished reset re-locks the write gate
    a_r8_relock: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !unlocked);

    // R2: locked writes leave the system register alone
    a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && host_wr && host_addr && !mac_rst) |=> $stable(sys));
endmodule

bind soft_reset_ctrl sr_checker #(.SYS_W(SYS_W), .PROT_MASK(PROT_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mac_rst   (mac_rst_o),
    .done      (done_evt),
    .timeout   (regs_q.timeout),
    .unlocked  (regs_q.unlocked),
    .host_wr   (host_wr_i),
    .host_addr (host_addr_i),
    .sys       (regs_q.sys),
    .err_tx    (regs_q.err_tx),
    .err_rx    (regs_q.err_rx)
);

// File: tb/soft_reset_ctrl_bench.sv
module soft_reset_ctrl_bench;
    localparam int RST_CYC     = 4;
    localparam int TIMEOUT_CYC = 64;
    localparam logic [7:0] PROT = 8'hF0;
    localparam logic [7:0] SRST = 8'h05;
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'hA3, 8'h5C, 8'h0F, 8'hF0};

    logic clk = 0, rst_n = 0;
    logic rx_clk = 0, tx_clk = 0, rx_run = 1, tx_run = 1;
    logic rd = 0, wr = 0, addr = 0, wake = 0, strap = 1, etx = 0, erx = 0;
    logic [7:0] wdata = 0, rdata;
    logic err_tx, err_rx, mac_rst;
    int n_tests = 0, n_fail = 0, strobes = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    always begin #40; if (rx_run) rx_clk = ~rx_clk; end
    always begin #56; if (tx_run) tx_clk = ~tx_clk; end
    always @(negedge clk) if (mac_rst) strobes++;

    soft_reset_ctrl u_soft_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .phy_rx_clk_i(rx_clk), .phy_tx_clk_i(tx_clk),
        .host_rd_i(rd), .host_wr_i(wr), .host_addr_i(addr), .host_wdata_i(wdata),
        .host_rdata_o(rdata), .wake_i(wake), .strap_bus32_i(strap),
        .err_tx_set_i(etx), .err_rx_set_i(erx), .err_tx_o(err_tx), .err_rx_o(err_rx),
        .mac_rst_o(mac_rst)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(logic a, output logic [7:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic hread(logic a, output logic [7:0] v);
        addr = a; rd = 1; #1; v = rdata;
        @(negedge clk); rd = 0;
    endtask

    task automatic hwrite(logic a, logic [7:0] d);
        addr = a; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic soft_reset();
        logic [7:0] v;
        hread(0, v);
        hwrite(0, 8'h01);
        cycles(12);
    endtask

    initial begin
        logic [7:0] v;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        cycles(2);
        strap = 0;
        // R1 reset state
        peek(0, v); check("R1 ctl", v[1:0], 2'b00);
        peek(1, v); check("R1 sys", v, SRST);
        check("R1 outs", {mac_rst, err_tx, err_rx}, 3'b000);
        // R2 locked write
        hwrite(1, 8'hEE); cycles(1);
        peek(1, v); check("R2 locked", v, SRST);
        // R9 strap sampled after reset, later change ignored
        peek(0, v); check("R9 bus32", v[2], 1'b1);
        cycles(30);
        // R11 writing 0 to busy bit
        hread(0, v); hwrite(0, 8'h00); cycles(1);
        peek(0, v); check("R11 no start", v[0], 1'b0);
        check("R11 no strobe", strobes, 0);
        // R3 completed reset
        hwrite(0, 8'h01);
        peek(0, v); check("R3 busy", v[0], 1'b1);
        cycles(12);
        peek(0, v); check("R3 cleared", v[1:0], 2'b00);
        check("R3 strobe cycles", strobes, RST_CYC);
        // R8 relocked after completion
        hwrite(1, 8'h77); cycles(1);
        peek(1, v); check("R8 after reset", v, SRST);
        // R6 table of system register vectors
        for (int i = 0; i < NVEC; i++) begin
            hread(1, v); hwrite(1, VEC[i]);
            peek(1, v); check("R6 write", v, VEC[i]);
            soft_reset();
            peek(1, v); check("R6 reload", v, (VEC[i] & PROT) | (SRST & ~PROT));
        end
        // R7 error latches
        etx = 1; erx = 1; @(negedge clk); etx = 0; erx = 0;
        check("R7 latched", {err_tx, err_rx}, 2'b11);
        soft_reset();
        check("R7 cleared", {err_tx, err_rx}, 2'b00);
        // R8 wake relocks
        hread(1, v); wake = 1; @(negedge clk); wake = 0;
        hwrite(1, 8'h99); cycles(1);
        peek(1, v); check("R8 wake", v, v == 8'h99 ? 8'h00 : v);
        peek(1, v); check("R8 wake val", v, (8'hF0 & PROT) | SRST);
        // R4 timeout with both clocks stopped
        rx_run = 0; tx_run = 0; cycles(40);
        strobes = 0;
        hread(0, v); hwrite(0, 8'h01); cycles(30);
        peek(0, v); check("R4 waiting", v[1:0], 2'b01);
        cycles(60);
        peek(0, v); check("R4 timed out", v[1:0], 2'b10);
        check("R4 no strobe", strobes, 0);
        // R5 new request clears the flag
        rx_run = 1; tx_run = 1; cycles(30);
        hwrite(0, 8'h01);
        peek(0, v); check("R5 flag cleared", v[1:0], 2'b01);
        cycles(12);
        check("R5 completed", strobes, RST_CYC);
        // R10 transmit clock alone stopped
        tx_run = 0; cycles(40); strobes = 0;
        hread(0, v); hwrite(0, 8'h01); cycles(TIMEOUT_CYC + 10);
        peek(0, v); check("R10 tx stopped", v[1:0], 2'b10);
        check("R10 no strobe", strobes, 0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule